// File: doc/BRIEF.md
# Thermal Supervisor with Rate-Based Throttling

This block keeps a board from overheating during a long test run. At a fixed interval it polls six temperature sensors one after another over a simple request/acknowledge port. It then compares every reading with a programmable trip level. If any reading is above that level, the block leaves normal operation and picks a protective action. The action depends on how quickly the temperature is climbing. A gentle rise slows the test engine down. A moderate rise pauses it. A steep rise asks for every board section other than the supervisor to be switched off.

The rise is measured per sensor as the increase since the previous scan. The largest increase over all six sensors is compared with two programmable rate limits. Once in a protective action, the block stays there until every reading has dropped below a separate, lower resume level, so the mode cannot chatter around a single threshold. Leaving slow-down or pause simply lets the test continue. Leaving shutdown also raises a one-cycle restart request. A sticky status word records the first sensor that tripped and the action taken, and a clear input resets it.

The scan interval is a cycle count parameter, so a short interval can be used in simulation.

Top module: `thermal_supervisor`

## Requirements
- R1: After a synchronous active-low reset, the throttle, pause, power-off and restart outputs are 0, the status word is 0 and no sensor request is raised.
- R2: A scan starts every SCAN_PERIOD clock cycles. It addresses sensors 0 to 5 in ascending order on `sns_sel`. `sns_req` and `sns_sel` are held stable until `sns_ack` is seen, and the reading on `sns_data` is captured in the same cycle as the acknowledge.
- R3: In normal mode, the block leaves normal mode at the end of a scan if any reading is strictly greater than `trip_level`. Readings equal to the trip level keep it in normal mode. The mode changes only at the end of a scan.
- R4: When tripping, the largest rise over all sensors selects the action. The rise of a sensor is (this scan's reading minus the previous scan's reading), or 0 if the reading did not increase. A rise at or above `rate_shut` asserts only `dom_power_off`. A rise at or above `rate_pause` but below `rate_shut` asserts only `eng_pause`. A smaller rise asserts only `eng_throttle`.
- R5: On the first scan after reset every rise counts as 0, so a trip on that scan selects slow-down.
- R6: While in a protective action, a scan with a reading above the trip level whose rise selects a more severe action escalates to that action. The severity order is slow-down < pause < shutdown. The block never moves to a milder protective action.
- R7: A protective action is kept until a scan in which every reading is strictly below `resume_level`. Readings between the two levels hold the current action.
- R8: On resuming, all action outputs drop to 0 at the end of that scan. `eng_restart` pulses high for exactly one cycle at that point only if the action that ended was shutdown.
- R9: `status_word` holds bit 5 = valid, bits 4:3 = action (1 slow-down, 2 pause, 3 shutdown) and bits 2:0 = the lowest-numbered sensor above the trip level. It is captured on a trip out of normal mode when it is not valid. Later trips and escalations leave it unchanged. A high `stat_clr` clears it, and a capture in the same cycle takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_level | input | 10 | Over-temperature level; a reading above it trips |
| resume_level | input | 10 | Safe level; all readings below it resume (must be below trip_level) |
| rate_pause | input | 10 | Rise limit selecting pause |
| rate_shut | input | 10 | Rise limit selecting shutdown |
| sns_req | output | 1 | Sensor read request |
| sns_sel | output | 3 | Index of the sensor being read |
| sns_ack | input | 1 | Sensor response valid |
| sns_data | input | 10 | Sensor reading |
| stat_clr | input | 1 | Clears the sticky status word |
| eng_throttle | output | 1 | Request to lower test engine speed |
| eng_pause | output | 1 | Request to pause the test engine |
| dom_power_off | output | 1 | Request to switch off the non-supervisor board sections |
| eng_restart | output | 1 | One-cycle request to restart the test after a shutdown |
| status_word | output | 6 | Sticky first-trip record |

## Verification
The sixth reading is captured on the edge that sees its acknowledge. A scan-done flag is registered on that edge, and the mode, the action outputs, the restart pulse and the status word all update on the edge that follows. The results are therefore due two edges after the last acknowledge and then stay constant until the next scan ends. The bench waits three falling edges after the last acknowledge before it compares the outputs. It counts the restart pulse with a monitor that samples every falling edge, so the pulse cannot be missed. The scan interval is checked as the time between the rising edges of the request on two consecutive scans.

// File: rtl/tsup_pkg.sv
`timescale 1ns/1ps
// Shared types for the thermal supervisor.
// The protective modes are ordered by severity so they can be compared numerically.
package tsup_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SLOW   = 2'd1,
        MODE_PAUSE  = 2'd2,
        MODE_SHUT   = 2'd3
    } tsup_mode_e;
endpackage

// File: rtl/tsup_scan.sv
`timescale 1ns/1ps
// tsup_scan: interval timer and sensor poller.
// Every SCAN_PERIOD cycles it reads NUM_SNS sensors in index order over a
// request/acknowledge port and stores the readings. It pulses scan_done one
// cycle after the last reading has been captured.
// Assumes the sensor side answers each request eventually; a tick that
// arrives while a scan is still running is skipped.
module tsup_scan #(
    parameter int NUM_SNS     = 6,
    parameter int TW          = 10,
    parameter int SCAN_PERIOD = 100_000_000,
    localparam int IDX_W = (NUM_SNS > 1) ? $clog2(NUM_SNS) : 1,
    localparam int CNT_W = (SCAN_PERIOD > 1) ? $clog2(SCAN_PERIOD) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic                  sns_req,
    output logic [IDX_W-1:0]      sns_sel,
    input  logic                  sns_ack,
    input  logic [TW-1:0]         sns_data,
    output logic [NUM_SNS*TW-1:0] readings,
    output logic                  scan_done
);
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [TW-1:0]    rd_q [NUM_SNS];

    assign tick    = (cnt_q == CNT_W'(SCAN_PERIOD - 1));
    assign sns_req = busy_q;
    assign sns_sel = idx_q;

    // Free-running interval counter that sets the scan rate.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Poll sequencer: walk the sensors in order and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            idx_q     <= '0;
            scan_done <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            if (!busy_q) begin
                if (tick) begin
                    busy_q <= 1'b1;
                    idx_q  <= '0;
                end
            end else if (sns_ack) begin
                if (idx_q == IDX_W'(NUM_SNS - 1)) begin
                    busy_q    <= 1'b0;
                    scan_done <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // One capture register per sensor, loaded when its acknowledge arrives.
    for (genvar g = 0; g < NUM_SNS; g++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q[g] <= '0;
            else if (busy_q && sns_ack && idx_q == IDX_W'(g))
                rd_q[g] <= sns_data;
        end
        assign readings[g*TW +: TW] = rd_q[g];
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sns_req && !sns_ack) |=> (sns_req && $stable(sns_sel))); // R2
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sns_req |-> (sns_sel <= IDX_W'(NUM_SNS - 1))); // R2
endmodule

// File: rtl/tsup_eval.sv
`timescale 1ns/1ps
// tsup_eval: judges one completed scan.
// For each sensor it flags readings above the trip level and below the
// resume level, and computes the rise since the previous scan (0 when the
// reading fell or when no previous scan exists). It reports the largest rise
// and the lowest index that is over the trip level. The previous readings are
// stored on scan_done.
// Assumes resume_level < trip_level.
module tsup_eval #(
    parameter int NUM_SNS = 6,
    parameter int TW      = 10,
    localparam int IDX_W = (NUM_SNS > 1) ? $clog2(NUM_SNS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_done,
    input  logic [NUM_SNS*TW-1:0] readings,
    input  logic [TW-1:0]         trip_level,
    input  logic [TW-1:0]         resume_level,
    output logic                  any_over,
    output logic                  all_below,
    output logic [TW-1:0]         max_rise,
    output logic [IDX_W-1:0]      first_idx
);
    logic [NUM_SNS-1:0] over;
    logic [NUM_SNS-1:0] below;
    logic [TW-1:0]      rise   [NUM_SNS];
    logic [TW-1:0]      prev_q [NUM_SNS];
    logic               prev_ok_q;

    // Marks that a previous scan is available for rise computation.
    always_ff @(posedge clk) begin
        if (!rst_n)         prev_ok_q <= 1'b0;
        else if (scan_done) prev_ok_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_SNS; g++) begin : g_sns
        logic [TW-1:0] cur;
        assign cur      = readings[g*TW +: TW];
        assign over[g]  = (cur > trip_level);
        assign below[g] = (cur < resume_level);
        assign rise[g]  = (prev_ok_q && cur > prev_q[g]) ? (cur - prev_q[g]) : '0;

        // Keeps this sensor's reading from the last finished scan.
        always_ff @(posedge clk) begin
            if (!rst_n)         prev_q[g] <= '0;
            else if (scan_done) prev_q[g] <= cur;
        end
    end

    assign any_over  = |over;
    assign all_below = &below;

    // Largest per-sensor rise in this scan.
    always_comb begin
        max_rise = '0;
        for (int k = 0; k < NUM_SNS; k++)
            if (rise[k] > max_rise) max_rise = rise[k];
    end

    // Lowest-numbered sensor above the trip level.
    always_comb begin
        first_idx = '0;
        for (int k = NUM_SNS - 1; k >= 0; k--)
            if (over[k]) first_idx = IDX_W'(k);
    end

    AST_BELOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_level < trip_level && all_below) |-> !any_over); // R7
endmodule

// File: rtl/tsup_mode.sv
`timescale 1ns/1ps
// tsup_mode: protective mode controller and sticky status.
// At each scan_done it trips out of normal mode, escalates the mode, or
// resumes according to the scan evaluation. It drives one action output per
// protective mode, a restart pulse after a shutdown, and the first-trip record.
// Assumes rate_pause <= rate_shut.
module tsup_mode
    import tsup_pkg::*;
#(
    parameter int NUM_SNS = 6,
    parameter int TW      = 10,
    localparam int IDX_W  = (NUM_SNS > 1) ? $clog2(NUM_SNS) : 1,
    localparam int STAT_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_done,
    input  logic              any_over,
    input  logic              all_below,
    input  logic [TW-1:0]     max_rise,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [TW-1:0]     rate_pause,
    input  logic [TW-1:0]     rate_shut,
    input  logic              stat_clr,
    output logic              eng_throttle,
    output logic              eng_pause,
    output logic              dom_power_off,
    output logic              eng_restart,
    output logic [STAT_W-1:0] status_word
);
    tsup_mode_e         mode_q;
    tsup_mode_e         pick;
    logic               restart_q;
    logic [STAT_W-1:0]  stat_q;
    logic               trip_entry;

    // Action chosen by the rise rate of this scan.
    always_comb begin
        if (max_rise >= rate_shut)       pick = MODE_SHUT;
        else if (max_rise >= rate_pause) pick = MODE_PAUSE;
        else                             pick = MODE_SLOW;
    end

    assign trip_entry = scan_done && (mode_q == MODE_NORMAL) && any_over;

    // Mode register: trip, escalate or resume, once per finished scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_NORMAL;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            if (scan_done) begin
                if (mode_q == MODE_NORMAL) begin
                    if (any_over) mode_q <= pick;
                end else if (all_below) begin
                    mode_q    <= MODE_NORMAL;
                    restart_q <= (mode_q == MODE_SHUT);
                end else if (any_over && pick > mode_q) begin
                    mode_q <= pick;
                end
            end
        end
    end

    // Sticky first-trip record; a capture takes precedence over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else if (trip_entry && (!stat_q[STAT_W-1] || stat_clr))
            stat_q <= {1'b1, 2'(pick), first_idx};
        else if (stat_clr)
            stat_q <= '0;
    end

    assign eng_throttle  = (mode_q == MODE_SLOW);
    assign eng_pause     = (mode_q == MODE_PAUSE);
    assign dom_power_off = (mode_q == MODE_SHUT);
    assign eng_restart   = restart_q;
    assign status_word   = stat_q;

    AST_MODE_ON_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_done |=> $stable(mode_q)); // R3
    AST_HOLD_UNTIL_COOL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_NORMAL && scan_done && !all_below) |=> (mode_q != MODE_NORMAL)); // R7
    AST_NO_DEESCALATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_NORMAL && !all_below) |=> (mode_q >= $past(mode_q))); // R6
    AST_RESTART_AFTER_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_restart |-> ($past(mode_q) == MODE_SHUT && mode_q == MODE_NORMAL)); // R8
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[STAT_W-1] && !stat_clr) |=> $stable(stat_q)); // R9
endmodule

// File: rtl/thermal_supervisor.sv
`timescale 1ns/1ps
// thermal_supervisor: top level. It polls the temperature sensors at a fixed
// interval, judges each finished scan, and drives the protective action,
// restart and status outputs.
// Assumes resume_level < trip_level and rate_pause <= rate_shut.
module thermal_supervisor #(
    parameter int NUM_SNS     = 6,
    parameter int TW          = 10,
    parameter int SCAN_PERIOD = 100_000_000,
    localparam int IDX_W  = (NUM_SNS > 1) ? $clog2(NUM_SNS) : 1,
    localparam int STAT_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     trip_level,
    input  logic [TW-1:0]     resume_level,
    input  logic [TW-1:0]     rate_pause,
    input  logic [TW-1:0]     rate_shut,
    output logic              sns_req,
    output logic [IDX_W-1:0]  sns_sel,
    input  logic              sns_ack,
    input  logic [TW-1:0]     sns_data,
    input  logic              stat_clr,
    output logic              eng_throttle,
    output logic              eng_pause,
    output logic              dom_power_off,
    output logic              eng_restart,
    output logic [STAT_W-1:0] status_word
);
    logic [NUM_SNS*TW-1:0] readings;
    logic                  scan_done;
    logic                  any_over;
    logic                  all_below;
    logic [TW-1:0]         max_rise;
    logic [IDX_W-1:0]      first_idx;

    tsup_scan #(.NUM_SNS(NUM_SNS), .TW(TW), .SCAN_PERIOD(SCAN_PERIOD)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .sns_req   (sns_req),
        .sns_sel   (sns_sel),
        .sns_ack   (sns_ack),
        .sns_data  (sns_data),
        .readings  (readings),
        .scan_done (scan_done)
    );

    tsup_eval #(.NUM_SNS(NUM_SNS), .TW(TW)) u_eval (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_done    (scan_done),
        .readings     (readings),
        .trip_level   (trip_level),
        .resume_level (resume_level),
        .any_over     (any_over),
        .all_below    (all_below),
        .max_rise     (max_rise),
        .first_idx    (first_idx)
    );

    tsup_mode #(.NUM_SNS(NUM_SNS), .TW(TW)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .scan_done     (scan_done),
        .any_over      (any_over),
        .all_below     (all_below),
        .max_rise      (max_rise),
        .first_idx     (first_idx),
        .rate_pause    (rate_pause),
        .rate_shut     (rate_shut),
        .stat_clr      (stat_clr),
        .eng_throttle  (eng_throttle),
        .eng_pause     (eng_pause),
        .dom_power_off (dom_power_off),
        .eng_restart   (eng_restart),
        .status_word   (status_word)
    );
endmodule

// File: tb/thermal_supervisor_test.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random scans, all checked
// against a requirement-level model kept in bench variables.
module thermal_supervisor_test;
    localparam int NS = 6;
    localparam int TW = 10;
    localparam int SP = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] trip_level   = 10'd600;
    logic [TW-1:0] resume_level = 10'd500;
    logic [TW-1:0] rate_pause   = 10'd20;
    logic [TW-1:0] rate_shut    = 10'd50;
    logic          sns_req;
    logic [2:0]    sns_sel;
    logic          sns_ack = 1'b0;
    logic [TW-1:0] sns_data = '0;
    logic          stat_clr = 1'b0;
    logic          eng_throttle, eng_pause, dom_power_off, eng_restart;
    logic [5:0]    status_word;

    thermal_supervisor #(.NUM_SNS(NS), .TW(TW), .SCAN_PERIOD(SP)) uut (
        .clk(clk), .rst_n(rst_n), .trip_level(trip_level), .resume_level(resume_level),
        .rate_pause(rate_pause), .rate_shut(rate_shut), .sns_req(sns_req),
        .sns_sel(sns_sel), .sns_ack(sns_ack), .sns_data(sns_data), .stat_clr(stat_clr),
        .eng_throttle(eng_throttle), .eng_pause(eng_pause), .dom_power_off(dom_power_off),
        .eng_restart(eng_restart), .status_word(status_word)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int rs_cnt = 0;
    int m_mode = 0;
    int m_stat = 0;
    int m_rs = 0;
    int m_prev [NS];
    bit m_prev_ok = 0;
    realtime last_start = 0;
    int n_starts = 0;

    // Counts restart pulses on every falling edge.
    always @(negedge clk) if (rst_n && eng_restart) rs_cnt++;

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pick_mode(input int rise);
        if (rise >= 50) return 3;
        if (rise >= 20) return 2;
        return 1;
    endfunction

    // Requirement model for one finished scan.
    task automatic model_scan(input int t[NS]);
        int mx = 0; bit over = 0; bit below = 1; int fi = -1; int p;
        for (int i = 0; i < NS; i++) begin
            int r = (m_prev_ok && t[i] > m_prev[i]) ? t[i] - m_prev[i] : 0;
            if (r > mx) mx = r;
            if (t[i] > 600) begin over = 1; if (fi < 0) fi = i; end
            if (!(t[i] < 500)) below = 0;
        end
        p = pick_mode(mx);
        if (m_mode == 0) begin
            if (over) begin
                m_mode = p;
                if (m_stat == 0) m_stat = 32 | (p << 3) | fi;
            end
        end else if (below) begin
            if (m_mode == 3) m_rs++;
            m_mode = 0;
        end else if (over && p > m_mode) m_mode = p;
        for (int i = 0; i < NS; i++) m_prev[i] = t[i];
        m_prev_ok = 1;
    endtask

    task automatic check_outputs(input string req);
        check(eng_throttle == (m_mode == 1), req, "throttle", eng_throttle, m_mode == 1);
        check(eng_pause == (m_mode == 2), req, "pause", eng_pause, m_mode == 2);
        check(dom_power_off == (m_mode == 3), req, "power_off", dom_power_off, m_mode == 3);
        check(int'(status_word) == m_stat, req, "status", status_word, m_stat);
        check(rs_cnt == m_rs, req, "restart count", rs_cnt, m_rs);
    endtask

    // Answers one full scan with the given readings, then checks the results.
    task automatic do_scan(input int t[NS], input string req);
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            while (!sns_req) @(negedge clk);
            if (i == 0) begin
                if (n_starts > 0)
                    check(($realtime - last_start) == SP * 5.0, "R2", "scan interval ns",
                          int'($realtime - last_start), SP * 5);
                last_start = $realtime;
                n_starts++;
            end
            if (int'(sns_sel) != i) check(0, "R2", "sensor order", sns_sel, i);
            sns_data = TW'(t[i]);
            sns_ack = 1'b1;
        end
        @(negedge clk); sns_ack = 1'b0;
        @(negedge clk); @(negedge clk);
        model_scan(t);
        check_outputs(req);
    endtask

    task automatic clear_status();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
        m_stat = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!eng_throttle && !eng_pause && !dom_power_off && !eng_restart, "R1", "actions in reset",
              {eng_throttle, eng_pause, dom_power_off, eng_restart}, 0);
        check(status_word == 0, "R1", "status in reset", status_word, 0);
        check(!sns_req, "R1", "request in reset", sns_req, 0);
        rst_n = 1'b1;
        m_mode = 0; m_stat = 0; m_prev_ok = 0; n_starts = 0;
        m_rs = rs_cnt;
    endtask

    function automatic void fill(ref int t[NS], input int v);
        for (int i = 0; i < NS; i++) t[i] = v;
    endfunction

    initial begin
        int t [NS];
        int seed_use;
        seed_use = $urandom(32'd7919);
        do_reset();

        fill(t, 400); do_scan(t, "R1");
        t[3] = 600; do_scan(t, "R3 at trip level stays normal");
        t[3] = 601; do_scan(t, "R3 R4 trip with small rise slows");
        fill(t, 580); do_scan(t, "R7 between levels holds");
        t[2] = 601; do_scan(t, "R6 R4 escalate to pause, R9 sticky");
        fill(t, 499); do_scan(t, "R8 resume from pause no restart");
        t[0] = 560; do_scan(t, "R3 rise without trip stays normal");
        t[0] = 610; do_scan(t, "R4 rise at shut limit shuts down");
        clear_status();
        check(status_word == 0, "R9", "status after clear", status_word, 0);
        fill(t, 520); t[1] = 601; do_scan(t, "R6 R7 no de-escalation");
        fill(t, 520); do_scan(t, "R7 hold shutdown");
        fill(t, 400); do_scan(t, "R8 resume from shutdown restarts");

        do_reset();
        fill(t, 400); t[5] = 700; do_scan(t, "R5 first scan rise is zero");
        fill(t, 400); do_scan(t, "R8 resume");

        for (int n = 0; n < 250; n++) begin
            for (int i = 0; i < NS; i++) begin
                int v = t[i] + int'($urandom_range(90)) - 30;
                if ($urandom_range(15) == 0) v = 420;
                if (v < 300) v = 300;
                if (v > 700) v = 700;
                t[i] = v;
            end
            if ($urandom_range(9) == 0) fill(t, 430);
            do_scan(t, "R3 R4 R6 R7 R8 R9 random");
            if ($urandom_range(7) == 0) clear_status();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule